// File: doc/BRIEF.md
# 1-Wire ROM Search Engine

This block walks the binary tree of 64-bit device identity codes on a 1-Wire bus and hands back one code per search call. It does not drive the wire itself. It sits above a bit-level slot engine and asks that engine for one operation at a time: a bus reset with presence detect, a single written bit, or a single read bit. Every search is built from these operations. It starts with a reset, sends the search command byte, and then repeats three steps for each code bit: read the bit, read its complement, write the chosen direction.

The search state is kept between calls. This state is the code register, the position of the last unresolved branch, the deepest branch taken inside the family field, and a flag that marks the final device. Because of this, successive search calls return every device on the bus in a fixed order. The host has three commands. It can start a search. It can clear the state, so that the next search begins from the first device. It can preset the state to a family code, so that the next search lands on the first device of that family.

Top module: `rom_search_engine`

## Requirements
- R1: While reset is held low, `busy`, `done`, `found` and `slot_req` are 0, and `rom_code` and `family_mark` are all zeros.
- R2: Every search that reaches the bus begins with a slot reset operation (`slot_op` = 0). If `slot_rbit` returns 0 (no presence), the search ends with `found` = 0 and the branch state is cleared.
- R3: After a successful reset, the command byte 0xF0 is sent as eight write operations (`slot_op` = 1), least significant bit first, with `slot_wbit` carrying the bit.
- R4: For each code position the engine issues two read operations (`slot_op` = 2): first the bit, then its complement. If both read 1, the search aborts with `found` = 0 and the branch state is cleared.
- R5: When the two reads differ, the direction is the first read. When both are 0, the direction is the stored code bit if the position lies below the last branch, 1 at the last branch, and 0 beyond it. The direction is stored at the current position (bit 0 first) and written back. As a result, devices come out in ascending order of their codes compared from bit 0 upward.
- R6: Whenever 0 is taken at a two-zero branch whose 1-based position is at most FAM_W, `family_mark` takes that position. It is never larger than FAM_W.
- R7: Once the final device has been returned, the next search reports `found` = 0 without any slot request, and the search after that starts again from the first device.
- R8: A completed search whose lowest FAM_W code bits are all zero reports `found` = 0 and clears the branch state.
- R9: `cmd_clear` zeroes `rom_code`, `family_mark` and the branch state, so that the next search returns the first device.
- R10: `cmd_target` loads `target_family` into the low FAM_W code bits and zeroes the rest. The next search returns the first device of that family, and later searches continue in the normal order.
- R11: Commands are ignored while `busy` is high. When several commands arrive together in idle, clear takes priority over target, and target over search.
- R12: `slot_req` is a single-cycle pulse. No new request is issued before `slot_done` has answered the previous one.
- R13: `done` is a one-cycle pulse with `busy` low. `found` and `rom_code` hold their values until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_search | input | 1 | Start one search call |
| cmd_clear | input | 1 | Clear the search state |
| cmd_target | input | 1 | Preset the state to a family code |
| target_family | input | FAM_W | Family code for the preset |
| busy | output | 1 | A search is in progress |
| done | output | 1 | Search call finished (pulse) |
| found | output | 1 | The last call returned a device |
| rom_code | output | ROM_W | Code register, bit 0 first on the bus |
| family_mark | output | clog2(FAM_W+1) | Deepest zero branch inside the family field |
| slot_req | output | 1 | Request one slot operation (pulse) |
| slot_op | output | 2 | 0 reset, 1 write bit, 2 read bit |
| slot_wbit | output | 1 | Bit to write |
| slot_done | input | 1 | Slot operation finished (pulse) |
| slot_rbit | input | 1 | Read bit, or presence after a reset |

## Verification
The bench uses the default parameters: a 64-bit code, an 8-bit family field and the 8-bit command 0xF0. With these values, branches at position 64 and the family boundary between positions 8 and 9 can both occur, and the bus model checks the exact command byte. A device set whose members branch both inside and outside the family field drives the full enumeration order, the last-device early exit, and the target preset that lands partway through the order.

// File: rtl/rom_search_engine.sv
module rom_search_engine #(
  parameter int ROM_W = 64,
  parameter int FAM_W = 8,
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] SEARCH_CMD = 8'hF0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_search,
  input  logic                         cmd_clear,
  input  logic                         cmd_target,
  input  logic [FAM_W-1:0]             target_family,
  output logic                         busy,
  output logic                         done,
  output logic                         found,
  output logic [ROM_W-1:0]             rom_code,
  output logic [$clog2(FAM_W+1)-1:0]   family_mark,
  output logic                         slot_req,
  output logic [1:0]                   slot_op,
  output logic                         slot_wbit,
  input  logic                         slot_done,
  input  logic                         slot_rbit
);
  localparam int IDXW = $clog2(ROM_W);
  localparam int POSW = $clog2(ROM_W + 1);
  localparam int FMW  = $clog2(FAM_W + 1);
  localparam int CCW  = $clog2(CMD_W);
  localparam logic [1:0] OP_RST = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_CMD, S_RDID, S_RDCMP, S_WRDIR} st_t;

  st_t             st;
  logic            waiting;
  logic [IDXW-1:0] bit_idx;
  logic [CCW-1:0]  cmd_cnt;
  logic            id_q, dir_q;
  logic [POSW-1:0] last_disc, last_zero;
  logic [FMW-1:0]  fam_q;
  logic            last_dev;
  logic [ROM_W-1:0] rom_q;
  logic            done_q, found_q;

  logic [POSW-1:0] pos;
  logic            dir_c, ans, last_bit, fail_c, start_c;

  assign pos      = POSW'(bit_idx) + POSW'(1);
  assign ans      = waiting && slot_done;
  assign last_bit = bit_idx == IDXW'(ROM_W - 1);
  assign dir_c    = (id_q != slot_rbit) ? id_q :
                    (pos < last_disc)   ? rom_q[bit_idx] :
                    (pos == last_disc);
  assign start_c  = st == S_IDLE && cmd_search && !cmd_clear && !cmd_target;
  assign fail_c   = (start_c && last_dev) ||
                    (ans && st == S_RST && !slot_rbit) ||
                    (ans && st == S_RDCMP && id_q && slot_rbit) ||
                    (ans && st == S_WRDIR && last_bit && rom_q[FAM_W-1:0] == '0);

  assign busy        = st != S_IDLE;
  assign done        = done_q;
  assign found       = found_q;
  assign rom_code    = rom_q;
  assign family_mark = fam_q;
  assign slot_req    = busy && !waiting;
  assign slot_wbit   = (st == S_CMD) ? SEARCH_CMD[cmd_cnt] : dir_q;

  always_comb begin
    case (st)
      S_RST:            slot_op = OP_RST;
      S_CMD, S_WRDIR:   slot_op = OP_WR;
      default:          slot_op = OP_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      waiting   <= 1'b0;
      bit_idx   <= '0;
      cmd_cnt   <= '0;
      id_q      <= 1'b0;
      dir_q     <= 1'b0;
      last_disc <= '0;
      last_zero <= '0;
      fam_q     <= '0;
      last_dev  <= 1'b0;
      rom_q     <= '0;
      done_q    <= 1'b0;
      found_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (slot_req) waiting <= 1'b1;
      if (ans) waiting <= 1'b0;
      if (fail_c) begin
        last_disc <= '0;
        last_dev  <= 1'b0;
        fam_q     <= '0;
        found_q   <= 1'b0;
        done_q    <= 1'b1;
        st        <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            if (cmd_clear) begin
              rom_q     <= '0;
              last_disc <= '0;
              fam_q     <= '0;
              last_dev  <= 1'b0;
            end else if (cmd_target) begin
              rom_q     <= {{(ROM_W-FAM_W){1'b0}}, target_family};
              last_disc <= POSW'(ROM_W);
              fam_q     <= '0;
              last_dev  <= 1'b0;
            end else if (cmd_search) begin
              st        <= S_RST;
              bit_idx   <= '0;
              cmd_cnt   <= '0;
              last_zero <= '0;
              found_q   <= 1'b0;
            end
          end
          S_RST: if (ans) st <= S_CMD;
          S_CMD: if (ans) begin
            cmd_cnt <= cmd_cnt + CCW'(1);
            if (cmd_cnt == CCW'(CMD_W - 1)) st <= S_RDID;
          end
          S_RDID: if (ans) begin
            id_q <= slot_rbit;
            st   <= S_RDCMP;
          end
          S_RDCMP: if (ans) begin
            rom_q[bit_idx] <= dir_c;
            dir_q          <= dir_c;
            if (!id_q && !slot_rbit && !dir_c) begin
              last_zero <= pos;
              if (pos <= POSW'(FAM_W)) fam_q <= FMW'(pos);
            end
            st <= S_WRDIR;
          end
          S_WRDIR: if (ans) begin
            if (last_bit) begin
              last_disc <= last_zero;
              last_dev  <= last_zero == '0;
              found_q   <= 1'b1;
              done_q    <= 1'b1;
              st        <= S_IDLE;
            end else begin
              bit_idx <= bit_idx + IDXW'(1);
              st      <= S_RDID;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rom_search_engine_chk.sv
module rom_search_engine_chk #(
  parameter int ROM_W = 64,
  parameter int FAM_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_clear,
  input logic                       cmd_target,
  input logic [FAM_W-1:0]           target_family,
  input logic                       busy,
  input logic                       done,
  input logic                       found,
  input logic [ROM_W-1:0]           rom_code,
  input logic [$clog2(FAM_W+1)-1:0] family_mark,
  input logic                       slot_req,
  input logic [1:0]                 slot_op,
  input logic                       slot_done
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (slot_req) outstanding <= 1'b1;
    else if (slot_done) outstanding <= 1'b0;
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) slot_req |-> !outstanding); // R12
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) slot_req |=> !slot_req); // R12
  AST_FIRST_OP_RESET: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (slot_req && slot_op == 2'd0)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !slot_req); // R13
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R13
  AST_FOUND_FAMILY: assert property (@(posedge clk) disable iff (!rst_n) (done && found) |-> rom_code[FAM_W-1:0] != '0); // R8
  AST_FAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n) family_mark <= FAM_W); // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (!busy && cmd_clear) |=> (rom_code == '0 && family_mark == '0)); // R9
  AST_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (!busy && cmd_target && !cmd_clear) |=> rom_code == {{(ROM_W-FAM_W){1'b0}}, $past(target_family)}); // R10
endmodule

bind rom_search_engine rom_search_engine_chk #(.ROM_W(ROM_W), .FAM_W(FAM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_clear(cmd_clear), .cmd_target(cmd_target),
  .target_family(target_family), .busy(busy), .done(done), .found(found),
  .rom_code(rom_code), .family_mark(family_mark), .slot_req(slot_req),
  .slot_op(slot_op), .slot_done(slot_done)
);

// File: tb/rom_search_engine_tb.sv
module rom_search_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_W = 64;
  localparam int FAM_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_search = 0, cmd_clear = 0, cmd_target = 0;
  logic [FAM_W-1:0] target_family = '0;
  logic busy, done, found, slot_req, slot_wbit;
  logic [ROM_W-1:0] rom_code;
  logic [3:0] family_mark;
  logic [1:0] slot_op;
  logic slot_done = 0, slot_rbit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_search_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_search(cmd_search), .cmd_clear(cmd_clear),
    .cmd_target(cmd_target), .target_family(target_family), .busy(busy), .done(done),
    .found(found), .rom_code(rom_code), .family_mark(family_mark), .slot_req(slot_req),
    .slot_op(slot_op), .slot_wbit(slot_wbit), .slot_done(slot_done), .slot_rbit(slot_rbit)
  );

  int checks = 0, failures = 0;

  // bus model
  logic [63:0] dev [8];
  int ndev = 0;
  bit fault = 0;
  bit sel [8];
  int cmd_bits, bitpos, ops = 0, pend = 0;
  logic [7:0] cmd_seen;
  bit rdphase;
  logic [1:0] pop;
  logic pwb;

  task automatic model_exec(output logic r);
    r = 1'b0;
    case (pop)
      2'd0: begin
        for (int i = 0; i < 8; i++) sel[i] = (i < ndev);
        cmd_bits = 0; cmd_seen = '0; bitpos = 0; rdphase = 0;
        r = (ndev > 0);
      end
      2'd1: begin
        if (cmd_bits < 8) begin
          cmd_seen[cmd_bits] = pwb;
          cmd_bits++;
        end else begin
          for (int i = 0; i < 8; i++)
            if (sel[i] && dev[i][bitpos] != pwb) sel[i] = 0;
          bitpos++;
        end
      end
      default: begin
        r = 1'b1;
        if (!fault)
          for (int i = 0; i < 8; i++)
            if (sel[i]) r = r & (rdphase ? ~dev[i][bitpos] : dev[i][bitpos]);
        rdphase = !rdphase;
      end
    endcase
  endtask

  always @(posedge clk) begin
    logic r;
    slot_done <= 1'b0;
    if (!rst_n) pend = 0;
    else if (slot_req) begin
      pend = 2; pop = slot_op; pwb = slot_wbit; ops++;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        model_exec(r);
        slot_rbit <= r;
        slot_done <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard
  bit          exp_f_q [$];
  logic [63:0] exp_r_q [$];
  string       exp_t_q [$];

  initial forever begin
    @(negedge clk);
    if (rst_n && done) begin
      if (exp_f_q.size() == 0) chk(0, "R13 unexpected done", 64'd1, 64'd0);
      else begin
        bit ef; logic [63:0] er; string et;
        ef = exp_f_q.pop_front(); er = exp_r_q.pop_front(); et = exp_t_q.pop_front();
        chk(found == ef, {et, " found"}, 64'(found), 64'(ef));
        if (ef) chk(rom_code == er, {et, " rom_code"}, rom_code, er);
      end
    end
  end

  // bus: 0 none, 1 reset only, 2 full with command
  task automatic do_search(input bit ef, input logic [63:0] er, input string tag,
                           input int bus, input bit inject);
    int ops0;
    ops0 = ops;
    exp_f_q.push_back(ef); exp_r_q.push_back(er); exp_t_q.push_back(tag);
    @(negedge clk) cmd_search = 1;
    @(negedge clk) cmd_search = 0;
    if (inject) begin
      repeat (30) @(negedge clk);
      cmd_clear = 1; cmd_target = 1; target_family = 8'hFF; cmd_search = 1;
      @(negedge clk) begin cmd_clear = 0; cmd_target = 0; cmd_search = 0; end
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    if (bus == 0) chk(ops == ops0, "R7 no slot request", 64'(ops - ops0), 64'd0);
    if (bus == 2) chk(cmd_seen == 8'hF0, "R3 command byte", 64'(cmd_seen), 64'hF0);
  endtask

  task automatic pulse_clear();
    @(negedge clk) cmd_clear = 1;
    @(negedge clk) cmd_clear = 0;
  endtask

  function automatic logic [63:0] rkey(input logic [63:0] v);
    logic [63:0] k;
    for (int i = 0; i < 64; i++) k[i] = v[63-i];
    return k;
  endfunction

  logic [63:0] ord [8];

  task automatic load_set(input int n);
    ndev = n;
    for (int i = 0; i < n; i++) ord[i] = dev[i];
    for (int i = 0; i < n; i++)
      for (int j = i + 1; j < n; j++)
        if (rkey(ord[j]) < rkey(ord[i])) begin
          logic [63:0] t;
          t = ord[i]; ord[i] = ord[j]; ord[j] = t;
        end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !found && !slot_req, "R1 reset flags", {busy, done, found, slot_req}, 0);
    chk(rom_code == 0 && family_mark == 0, "R1 reset state", rom_code, 0);
    rst_n = 1;
    @(negedge clk);

    ndev = 0;
    do_search(0, 0, "R2 empty bus", 1, 0);

    dev[0] = 64'h0000_0000_0000_A110;
    dev[1] = 64'h0000_0000_0000_B128;
    dev[2] = 64'h1234_5678_9ABC_DE28;
    dev[3] = 64'h8000_0000_0000_0001;
    load_set(4);

    do_search(1, ord[0], "R5 first device", 2, 0);
    chk(family_mark == 4, "R6 family mark", 64'(family_mark), 64'd4);
    do_search(1, ord[1], "R5 second device", 2, 0);
    do_search(1, ord[2], "R5 third device", 2, 0);
    do_search(1, ord[3], "R5 fourth device", 2, 0);
    do_search(0, 0, "R7 after last device", 0, 0);
    do_search(1, ord[0], "R7 restart", 2, 0);

    pulse_clear();
    @(negedge clk);
    chk(rom_code == 0 && family_mark == 0, "R9 clear state", rom_code, 0);
    do_search(1, ord[0], "R9 after clear", 2, 0);

    @(negedge clk) begin cmd_target = 1; target_family = 8'h28; end
    @(negedge clk) cmd_target = 0;
    chk(rom_code == 64'h28, "R10 target preset", rom_code, 64'h28);
    k = 0;
    while (ord[k][7:0] != 8'h28) k++;
    do_search(1, ord[k], "R10 target first", 2, 0);
    do_search(1, ord[k+1], "R10 continue order", 2, 0);

    pulse_clear();
    do_search(1, ord[0], "R11 busy inject", 2, 1);
    do_search(1, ord[1], "R11 state intact", 2, 0);

    @(negedge clk) begin cmd_clear = 1; cmd_search = 1; end
    @(negedge clk) begin cmd_clear = 0; cmd_search = 0; end
    repeat (5) @(negedge clk);
    chk(!busy && rom_code == 0, "R11 clear over search", rom_code, 0);

    fault = 1;
    do_search(0, 0, "R4 both ones abort", 2, 0);
    fault = 0;
    do_search(1, ord[0], "R4 state cleared", 2, 0);

    dev[0] = 64'hCAFE_0000_0000_4400;
    load_set(1);
    do_search(0, 0, "R8 zero family", 2, 0);
    do_search(0, 0, "R8 bus used again", 2, 0);

    dev[0] = 64'h0102_0304_0506_0777;
    load_set(1);
    do_search(1, dev[0], "R5 single device", 2, 0);
    chk(slot_req == 0 && !busy, "R12 quiet after done", 64'(slot_req), 0);
    do_search(0, 0, "R7 single last", 0, 0);
    do_search(1, dev[0], "R7 single restart", 2, 0);

    repeat (5) @(negedge clk);
    chk(exp_f_q.size() == 0, "R13 all results seen", exp_f_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule